// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

The resolver decides whether a bank of eight interrupt lines should interrupt the processor, and which line wins. A line is a candidate when it is pending and not masked. Candidates are ranked from a programmable rotation base: rank 0 is the line at the base position, and the rank rises as the line number climbs from the base, wrapping modulo 8. The best candidate raises the request output only when its rank is strictly better than the best rank of the lines already in service.

The block does not own the pending, in-service or base registers. A surrounding register file feeds their present values in and takes back the next values the block computes. On an acknowledge strobe the winning line is moved into service. Its pending bit is dropped if the line is edge-triggered. An automatic end-of-interrupt mode can retire the line at once and, if selected, rotate the base to just past it. The vector for the acknowledged line appears one cycle later. When the acknowledge finds no winner, the vector names line 7 as a spurious interrupt. A nested mode, present only in the primary instance, leaves the cascade input out of the in-service comparison so that a secondary controller can present a deeper request through that input.

Top module: `irq_resolver`

## Requirements
- R1: Line L has rank (L - base) mod 8 and rank 0 is best. The winner is the candidate with the smallest rank.
- R2: The candidate set is pend_i AND NOT mask_i. When that set is empty, int_req_o is 0.
- R3: int_req_o is 1 only when the winner's rank is strictly smaller than the best rank in the in-service set. An empty in-service set never blocks a candidate. A candidate of equal or worse rank does not interrupt.
- R4: With nested_i = 1 in the primary instance, in-service bit 2 (the cascade line) is left out of the in-service rank. With nested_i = 0 it counts.
- R5: On ack_i with a winner on line L, insvc_nxt_o[L] becomes 1. pend_nxt_o[L] becomes 0 only when level_i[L] = 0 (edge-triggered). A level-triggered line (level_i[L] = 1) stays pending.
- R6: With auto_eoi_i = 1, an acknowledge leaves insvc_nxt_o[L] = 0. If rot_aeoi_i is also 1, base_nxt_o = (L + 1) mod 8. Otherwise base_nxt_o = base_i.
- R7: An acknowledge with no winner returns line 7 in the vector and leaves every next-state output equal to its input.
- R8: The cycle after ack_i, vec_vld_o is 1 and vec_o = {vbase_i, line}, with the 5-bit vbase_i in bits 7:3 and the 3-bit line in bits 2:0. vec_o holds its value between acknowledges, and vec_vld_o is 0 in the cycle after a cycle without ack_i.
- R9: A synchronous active-low reset clears vec_o and vec_vld_o to 0.
- R10: While ack_i is 0, pend_nxt_o, insvc_nxt_o and base_nxt_o equal pend_i, insvc_i and base_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 8 | Pending request bits |
| mask_i | input | 8 | Mask bits, 1 = masked |
| insvc_i | input | 8 | In-service bits |
| level_i | input | 8 | Trigger type per line, 1 = level, 0 = edge |
| base_i | input | 3 | Rotation base, the line of rank 0 |
| vbase_i | input | 5 | Upper bits of the returned vector |
| auto_eoi_i | input | 1 | Retire the line on acknowledge |
| rot_aeoi_i | input | 1 | Rotate the base on an automatic end-of-interrupt |
| nested_i | input | 1 | Leave the cascade line out of the in-service rank |
| ack_i | input | 1 | Acknowledge strobe |
| int_req_o | output | 1 | Interrupt request, combinational |
| pend_nxt_o | output | 8 | Next pending bits |
| insvc_nxt_o | output | 8 | Next in-service bits |
| base_nxt_o | output | 3 | Next rotation base |
| vec_o | output | 8 | Vector of the last acknowledge |
| vec_vld_o | output | 1 | Pulses the cycle after an acknowledge |

## Verification
The same pending pattern is run under base 0 and base 1 to show that the winner moves with the rotation and is not a fixed lowest-number choice. In-service sets are placed at, above and below the candidate's rank to separate strict from non-strict comparison, and a busy cascade line is tried with the nested mode on and off. Acknowledges are given on edge and level lines and in each end-of-interrupt mode, plus one with no candidate, to tell the pending-clear rule, the retire and rotate rules and the spurious vector apart. Long random runs then compare every output against a rank-by-rank model on every clock.

// File: rtl/irq_res_pkg.sv
// Package irq_res_pkg
// Shared types for the interrupt resolver. Assumes nothing beyond
// being compiled ahead of the modules that import it.
package irq_res_pkg;

    // Mode bits that steer the acknowledge update.
    typedef struct packed {
        logic auto_eoi;
        logic rot_aeoi;
        logic nested;
    } irq_mode_t;

    // Result of one rotated priority search.
    typedef struct packed {
        logic hit;
        logic [7:0] spare;
    } irq_scan_pad_t;

endpackage

// File: rtl/irq_prio_scan.sv
// Module irq_prio_scan
// Finds the best-ranked set bit of a request vector. The rank of a
// line is its distance upward from the base, modulo N.
// Assumes N is a power of two, so index arithmetic wraps on its own.
module irq_prio_scan #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [LW-1:0] base,
    output logic          hit,
    output logic [LW-1:0] rank,
    output logic [LW-1:0] line
);

    logic [N-1:0] rot;

    // Rotate the request vector so that rank p sits at bit p.
    always_comb begin
        rot = '0;
        for (int p = 0; p < N; p++) begin
            rot[p] = req[LW'(p) + base];
        end
    end

    // Pick the lowest set rank; scanning down leaves the smallest.
    always_comb begin
        hit  = 1'b0;
        rank = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (rot[p]) begin
                hit  = 1'b1;
                rank = LW'(p);
            end
        end
    end

    // Map the winning rank back to a physical line.
    assign line = rank + base;

endmodule

// File: rtl/irq_ack_update.sv
// Module irq_ack_update
// Computes the next pending, in-service and base values for one
// acknowledge. Assumes fire and line come from the resolver in the
// same cycle. Without ack the registers pass through unchanged.
module irq_ack_update
    import irq_res_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          ack,
    input  logic          fire,
    input  logic [LW-1:0] line,
    input  irq_mode_t     mode,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  insvc,
    input  logic [N-1:0]  level,
    input  logic [LW-1:0] base,
    output logic [N-1:0]  pend_nxt,
    output logic [N-1:0]  insvc_nxt,
    output logic [LW-1:0] base_nxt,
    output logic [LW-1:0] take_line
);

    localparam logic [LW-1:0] SPURIOUS = LW'(N - 1);

    logic [N-1:0] onehot;
    logic         take;

    // One-hot of the winning line and whether it is actually taken.
    always_comb begin
        onehot = '0;
        onehot[line] = 1'b1;
        take = ack && fire;
    end

    // Register updates for a taken acknowledge.
    always_comb begin
        pend_nxt  = pend;
        insvc_nxt = insvc;
        base_nxt  = base;
        if (take) begin
            pend_nxt = pend & ~(onehot & ~level);
            if (mode.auto_eoi) begin
                insvc_nxt = insvc & ~onehot;
                if (mode.rot_aeoi) begin
                    base_nxt = line + LW'(1);
                end
            end else begin
                insvc_nxt = insvc | onehot;
            end
        end
    end

    // Line reported in the vector: winner, or spurious line N-1.
    assign take_line = fire ? line : SPURIOUS;

endmodule

// File: rtl/irq_resolver.sv
// Module irq_resolver
// Top of the rotating-priority resolver. Raises int_req_o when the best
// candidate strictly outranks the in-service set. Computes the state
// update for an acknowledge and registers the returned vector.
// Assumes the caller owns the pending, in-service and base registers.
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter int N            = 8,
    parameter int VEC_W        = 8,
    parameter int CASCADE_LINE = 2,
    parameter bit IS_PRIMARY   = 1'b1,
    parameter int LW           = $clog2(N),
    parameter int VB_W         = VEC_W - LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_i,
    input  logic [N-1:0]     mask_i,
    input  logic [N-1:0]     insvc_i,
    input  logic [N-1:0]     level_i,
    input  logic [LW-1:0]    base_i,
    input  logic [VB_W-1:0]  vbase_i,
    input  logic             auto_eoi_i,
    input  logic             rot_aeoi_i,
    input  logic             nested_i,
    input  logic             ack_i,
    output logic             int_req_o,
    output logic [N-1:0]     pend_nxt_o,
    output logic [N-1:0]     insvc_nxt_o,
    output logic [LW-1:0]    base_nxt_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_vld_o
);

    irq_mode_t     mode;
    logic [N-1:0]  cand;
    logic [N-1:0]  svc_eff;
    logic          cand_hit, svc_hit;
    logic [LW-1:0] cand_rank, svc_rank, cand_line, svc_line, take_line;
    logic          fire;

    // Gather the mode bits into one bundle.
    assign mode = '{auto_eoi: auto_eoi_i, rot_aeoi: rot_aeoi_i, nested: nested_i};

    // Candidate set: pending and not masked.
    assign cand = pend_i & ~mask_i;

    // In-service set for the comparison; the primary may drop the cascade bit.
    generate
        if (IS_PRIMARY) begin : g_primary
            always_comb begin
                svc_eff = insvc_i;
                if (mode.nested) begin
                    svc_eff[CASCADE_LINE] = 1'b0;
                end
            end
        end else begin : g_secondary
            assign svc_eff = insvc_i;
        end
    endgenerate

    irq_prio_scan #(.N(N), .LW(LW)) u_cand_scan (
        .req  (cand),
        .base (base_i),
        .hit  (cand_hit),
        .rank (cand_rank),
        .line (cand_line)
    );

    irq_prio_scan #(.N(N), .LW(LW)) u_svc_scan (
        .req  (svc_eff),
        .base (base_i),
        .hit  (svc_hit),
        .rank (svc_rank),
        .line (svc_line)
    );

    // Strict comparison of candidate rank against in-service rank.
    always_comb begin
        fire = cand_hit && (!svc_hit || (cand_rank < svc_rank));
    end

    assign int_req_o = fire;

    irq_ack_update #(.N(N), .LW(LW)) u_ack (
        .ack       (ack_i),
        .fire      (fire),
        .line      (cand_line),
        .mode      (mode),
        .pend      (pend_i),
        .insvc     (insvc_i),
        .level     (level_i),
        .base      (base_i),
        .pend_nxt  (pend_nxt_o),
        .insvc_nxt (insvc_nxt_o),
        .base_nxt  (base_nxt_o),
        .take_line (take_line)
    );

    // Register the vector of each acknowledge and pulse its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o     <= '0;
            vec_vld_o <= 1'b0;
        end else begin
            vec_vld_o <= ack_i;
            if (ack_i) begin
                vec_o <= {vbase_i, take_line};
            end
        end
    end

    // svc_line is only a by-product of the shared scanner.
    logic unused_ok;
    assign unused_ok = ^svc_line;

endmodule

// File: rtl/irq_resolver_chk.sv
// Module irq_resolver_chk
// Property checker bound into irq_resolver. It watches only the ports.
module irq_resolver_chk #(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    parameter int LW    = $clog2(N),
    parameter int VB_W  = VEC_W - LW
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     pend_i,
    input logic [N-1:0]     mask_i,
    input logic [N-1:0]     insvc_i,
    input logic [LW-1:0]    base_i,
    input logic [VB_W-1:0]  vbase_i,
    input logic             auto_eoi_i,
    input logic             nested_i,
    input logic             ack_i,
    input logic             int_req_o,
    input logic [N-1:0]     pend_nxt_o,
    input logic [N-1:0]     insvc_nxt_o,
    input logic [LW-1:0]    base_nxt_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_vld_o
);

    assert_no_cand_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~mask_i) == '0) |-> !int_req_o);

    assert_idle_svc_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((insvc_i == '0) && ((pend_i & ~mask_i) != '0)) |-> int_req_o);

    assert_all_in_service_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nested_i && ((pend_i & ~mask_i & ~insvc_i) == '0)) |-> !int_req_o);

    assert_ack_adds_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_req_o && !auto_eoi_i && !nested_i)
        |-> ($countones(insvc_nxt_o) == $countones(insvc_i) + 1));

    assert_aeoi_no_new_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && auto_eoi_i) |-> ((insvc_nxt_o & ~insvc_i) == '0));

    assert_spurious_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_req_o) |=> (vec_o[LW-1:0] == {LW{1'b1}}));

    assert_vld_follows_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_vld_o);

    assert_vld_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_vld_o);

    assert_vec_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (vec_o[VEC_W-1:LW] == $past(vbase_i)));

    assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |-> ((pend_nxt_o == pend_i) && (insvc_nxt_o == insvc_i)
                    && (base_nxt_o == base_i)));

endmodule

bind irq_resolver irq_resolver_chk #(.N(N), .VEC_W(VEC_W), .LW(LW), .VB_W(VB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend_i),
    .mask_i      (mask_i),
    .insvc_i     (insvc_i),
    .base_i      (base_i),
    .vbase_i     (vbase_i),
    .auto_eoi_i  (auto_eoi_i),
    .nested_i    (nested_i),
    .ack_i       (ack_i),
    .int_req_o   (int_req_o),
    .pend_nxt_o  (pend_nxt_o),
    .insvc_nxt_o (insvc_nxt_o),
    .base_nxt_o  (base_nxt_o),
    .vec_o       (vec_o),
    .vec_vld_o   (vec_vld_o)
);

// File: tb/sim_irq_resolver.sv
// Bench for irq_resolver: a rank-by-rank model compared on every clock.
module sim_irq_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pend_i = '0, mask_i = '0, insvc_i = '0, level_i = '0;
    logic [2:0] base_i = '0;
    logic [4:0] vbase_i = '0;
    logic       auto_eoi_i = 1'b0, rot_aeoi_i = 1'b0, nested_i = 1'b0, ack_i = 1'b0;
    logic       int_req_o, vec_vld_o;
    logic [7:0] pend_nxt_o, insvc_nxt_o, vec_o;
    logic [2:0] base_nxt_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_vec = '0;
    logic       exp_vld = 1'b0;

    always #10 clk = ~clk;

    irq_resolver u0 (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i),
        .insvc_i(insvc_i), .level_i(level_i), .base_i(base_i), .vbase_i(vbase_i),
        .auto_eoi_i(auto_eoi_i), .rot_aeoi_i(rot_aeoi_i), .nested_i(nested_i),
        .ack_i(ack_i), .int_req_o(int_req_o), .pend_nxt_o(pend_nxt_o),
        .insvc_nxt_o(insvc_nxt_o), .base_nxt_o(base_nxt_o), .vec_o(vec_o),
        .vec_vld_o(vec_vld_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Rank of the best set bit counting upward from base; 8 if none.
    function automatic int best_rank(input logic [7:0] m, input int b);
        for (int p = 0; p < 8; p++) begin
            if (m[(p + b) % 8]) return p;
        end
        return 8;
    endfunction

    task automatic step(input string tag, input logic [7:0] pend, input logic [7:0] mask,
                        input logic [7:0] isv, input logic [7:0] lvl, input int base,
                        input logic [4:0] vb, input logic aeoi, input logic rot,
                        input logic nest, input logic ack, input logic rst_hi);
        logic [7:0] cand, svc, e_pend, e_isv, nvec;
        int cr, sr, line, e_base;
        bit fire;
        @(negedge clk);
        rst_n = rst_hi; pend_i = pend; mask_i = mask; insvc_i = isv; level_i = lvl;
        base_i = 3'(base); vbase_i = vb; auto_eoi_i = aeoi; rot_aeoi_i = rot;
        nested_i = nest; ack_i = ack;
        #5;
        // Registered vector from the previous cycle (R8, R9).
        chk(tag, "vec_vld_o (R8/R9)", int'(vec_vld_o), int'(exp_vld));
        chk(tag, "vec_o (R8/R9)", int'(vec_o), int'(exp_vec));
        cand = pend & ~mask;
        svc = isv;
        if (nest) svc[2] = 1'b0;
        cr = best_rank(cand, base);
        sr = best_rank(svc, base);
        fire = (cr < 8) && (cr < sr);
        line = fire ? (cr + base) % 8 : 7;
        e_pend = pend; e_isv = isv; e_base = base;
        if (ack && fire) begin
            if (!lvl[line]) e_pend[line] = 1'b0;
            if (aeoi) begin
                e_isv[line] = 1'b0;
                if (rot) e_base = (line + 1) % 8;
            end else begin
                e_isv[line] = 1'b1;
            end
        end
        nvec = {vb, 3'(line)};
        chk(tag, "int_req_o (R1-R4)", int'(int_req_o), int'(fire));
        chk(tag, "pend_nxt_o (R5/R10)", int'(pend_nxt_o), int'(e_pend));
        chk(tag, "insvc_nxt_o (R5/R6)", int'(insvc_nxt_o), int'(e_isv));
        chk(tag, "base_nxt_o (R6/R7)", int'(base_nxt_o), e_base);
        if (!rst_hi) begin
            exp_vld = 1'b0; exp_vec = '0;
        end else begin
            exp_vld = ack;
            if (ack) exp_vec = nvec;
        end
    endtask

    initial begin
        // R9: reset with activity on the inputs.
        for (int i = 0; i < 3; i++)
            step("R9", 8'h01, 8'h00, 8'h00, 8'h00, 0, 5'h08, 0, 0, 0, 1, 0);
        // R1: same requests under two bases.
        step("R1", 8'h81, 8'h00, 8'h00, 8'h00, 0, 5'h08, 0, 0, 0, 1, 1);
        step("R1", 8'h81, 8'h00, 8'h00, 8'h00, 1, 5'h08, 0, 0, 0, 1, 1);
        step("R1", 8'h28, 8'h00, 8'h00, 8'h00, 4, 5'h03, 0, 0, 0, 1, 1);
        // R2: everything masked, then partly masked.
        step("R2", 8'hFF, 8'hFF, 8'h00, 8'h00, 0, 5'h01, 0, 0, 0, 0, 1);
        step("R2", 8'h06, 8'h02, 8'h00, 8'h00, 0, 5'h01, 0, 0, 0, 1, 1);
        // R3: in-service at, above and below the candidate.
        step("R3", 8'h08, 8'h00, 8'h08, 8'h00, 0, 5'h02, 0, 0, 0, 0, 1);
        step("R3", 8'h02, 8'h00, 8'h08, 8'h00, 0, 5'h02, 0, 0, 0, 0, 1);
        step("R3", 8'h20, 8'h00, 8'h08, 8'h00, 0, 5'h02, 0, 0, 0, 0, 1);
        // R4: busy cascade line with nested mode off and on.
        step("R4", 8'h04, 8'h00, 8'h04, 8'h00, 0, 5'h04, 0, 0, 0, 0, 1);
        step("R4", 8'h04, 8'h00, 8'h04, 8'h00, 0, 5'h04, 0, 0, 1, 1, 1);
        // R5: edge line cleared, level line kept.
        step("R5", 8'h10, 8'h00, 8'h00, 8'h00, 0, 5'h05, 0, 0, 0, 1, 1);
        step("R5", 8'h10, 8'h00, 8'h00, 8'h10, 0, 5'h05, 0, 0, 0, 1, 1);
        // R6: automatic EOI without and with rotation, including wrap.
        step("R6", 8'h20, 8'h00, 8'h00, 8'h00, 0, 5'h06, 1, 0, 0, 1, 1);
        step("R6", 8'h20, 8'h00, 8'h00, 8'h00, 0, 5'h06, 1, 1, 0, 1, 1);
        step("R6", 8'h80, 8'h00, 8'h00, 8'h00, 3, 5'h06, 1, 1, 0, 1, 1);
        // R7: acknowledge with nothing to take.
        step("R7", 8'h00, 8'h00, 8'h01, 8'h00, 0, 5'h1F, 1, 1, 0, 1, 1);
        step("R7", 8'h40, 8'h40, 8'h00, 8'h00, 2, 5'h0A, 0, 0, 0, 1, 1);
        // R8/R10: idle cycle, vector held.
        step("R10", 8'h33, 8'h00, 8'h44, 8'h0F, 5, 5'h0B, 1, 1, 1, 0, 1);
        // Random mix of everything.
        for (int i = 0; i < 2000; i++)
            step("RND", 8'($urandom), 8'($urandom), 8'($urandom & $urandom), 8'($urandom),
                 int'($urandom % 8), 5'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom % 50 != 0));
        step("R8", 8'h00, 8'h00, 8'h00, 8'h00, 0, 5'h00, 0, 0, 0, 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule